// File: doc/BRIEF.md
# Looping Playback Address Generator

This block drives the read address of a waveform memory during playback. It divides a fast reference clock into a selectable sample rate and steps the address once per sample period. Each pass begins at a programmed start address and climbs to the highest memory location, then begins again at the start address. Only the upper part of memory, where the waveform sits, is played. The output frequency is therefore the sample rate divided by the number of addresses in that region.

A trigger output goes with the address stream. In pulse mode it rises whenever a pass begins and stays high for a fixed number of sample periods. In square mode it follows the most significant bit of the memory data word, which is high for samples above mid-scale, captured once per sample. A filter-enable output reports whether the selected rate calls for the reconstruction filter.

Top module: `loop_playback_addr`

## Requirements
- R1: While `rstN` is low, `memAddr` is all ones (the top of memory) and `trigOut` is low. The sample divider restarts from zero when `rstN` rises.
- R2: `sampleEn` is high for one clock in every D clocks. D = RATE_STEP^n, where n is the value of `rateSel` taken as an unsigned number for codes 1 to 5. Codes 0, 6 and 7 give D = 1, so `sampleEn` is high on every clock. The first strobe comes in the D-th clock after reset is released.
- R3: `filterOn` is high for every `rateSel` code except 3'b000.
- R4: On a clock with `sampleEn` high and `memAddr` below the top, `memAddr` rises by one. On a clock with `sampleEn` low, it holds its value.
- R5: On a clock with `sampleEn` high and `memAddr` all ones, `memAddr` loads `startAddr`. The first strobe after reset therefore lands on `startAddr`, and the address sequence repeats every 2^ADDR_W - `startAddr` strobes.
- R6: With `trigSel` low, `trigOut` rises on each reload to `startAddr` and stays high for TRIG_LEN strobes, counting the reload strobe. A reload that comes while it is high restarts the count.
- R7: With `startAddr` all ones, every strobe reloads the same address, so the address never changes. With `trigSel` low, `trigOut` then stays high from the first strobe on.
- R8: With `trigSel` high, `trigOut` equals the value `dataMsb` had at the most recent strobe, and is low before the first strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (nominally 32 MHz) |
| rstN | input | 1 | Active-low asynchronous reset of the counters and trigger |
| rateSel | input | 3 | Sample rate code |
| startAddr | input | ADDR_W | First address of the played region |
| trigSel | input | 1 | 0 = pulse at each pass start, 1 = square wave from data MSB |
| dataMsb | input | 1 | Most significant bit of the memory word at `memAddr` |
| memAddr | output | ADDR_W | Waveform memory read address |
| sampleEn | output | 1 | One-clock strobe marking each sample step |
| filterOn | output | 1 | High when the reconstruction filter should be enabled |
| trigOut | output | 1 | Trigger output |

## Verification
The bench sweeps every rate code against start addresses at zero, in the middle, just below the top and at the top, in both trigger modes. Codes 6 and 7 are the corner cases for the divider: a design that decoded them as slow rates would space its strobes far too widely. A region shorter than the trigger pulse and a single-address region are the corner cases for the pulse: a counter that did not restart on each reload would let the trigger drop between passes. An off-by-one at the top would play one stray address or skip the last one, and that shows up as the wrong sequence length.

// File: rtl/lpag_pkg.sv
package lpag_pkg;

  typedef struct packed {
    logic tick;    // advance one sample
    logic reload;  // advance by reloading the start address
  } lpagStrobe_t;

  function automatic int ipow(input int base, input int expo);
    int acc;
    acc = 1;
    for (int i = 0; i < expo; i++) acc = acc * base;
    return acc;
  endfunction

endpackage

// File: rtl/lpag_ctrl.sv
module lpag_ctrl
  import lpag_pkg::*;
#(
  parameter int RATE_STEP = 10,
  parameter int NUM_RATES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  rateSel,
  input  logic        atTop,
  output lpagStrobe_t strb,
  output logic        filterOn
);

  localparam int MAX_DIV = ipow(RATE_STEP, NUM_RATES - 1);
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] lastTab [8];
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic             tick;

  // terminal count per rate code; unused codes run at the full rate
  for (genvar g = 0; g < 8; g++) begin : gTab
    if (g < NUM_RATES) begin : gUsed
      assign lastTab[g] = DIV_W'(ipow(RATE_STEP, g) - 1);
    end else begin : gFast
      assign lastTab[g] = '0;
    end
  end

  assign divLast = lastTab[rateSel];
  assign tick    = (divCnt >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  assign strb.tick   = tick;
  assign strb.reload = tick & atTop;
  assign filterOn    = |rateSel;

  // R2: each strobe restarts the divider
  a_r2_divider_restart: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (divCnt == '0));

  // R2: no strobe while the count is below the terminal value of a steady code
  a_r2_no_early_tick: assert property (@(posedge clk) disable iff (!rstN)
    (divCnt < divLast) |-> !strb.tick);

endmodule

// File: rtl/lpag_dpath.sv
module lpag_dpath
  import lpag_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int TRIG_LEN = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpagStrobe_t       strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              trigSel,
  input  logic              dataMsb,
  output logic [ADDR_W-1:0] memAddr,
  output logic              atTop,
  output logic              trigOut
);

  localparam int PULSE_W = $clog2(TRIG_LEN + 1);

  logic [PULSE_W-1:0] pulseCnt;
  logic               sqBit;
  logic               pulseOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '1;
      pulseCnt <= '0;
      sqBit    <= 1'b0;
    end else if (strb.tick) begin
      memAddr <= strb.reload ? startAddr : memAddr + 1'b1;
      sqBit   <= dataMsb;
      if (strb.reload)        pulseCnt <= PULSE_W'(TRIG_LEN);
      else if (pulseCnt != 0) pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign atTop   = &memAddr;
  assign pulseOn = (pulseCnt != '0);
  assign trigOut = trigSel ? sqBit : pulseOn;

  // R4: address holds between strobes
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> $stable(memAddr));

  // R4: plain strobe steps by one
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.reload) |=> (memAddr == $past(memAddr) + 1'b1));

  // R5: reload strobe lands on the start address
  a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (memAddr == $past(startAddr)));

  // R6: a reload always leaves the pulse running
  a_r6_pulse_start: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> pulseOn);

endmodule

// File: rtl/loop_playback_addr.sv
module loop_playback_addr
  import lpag_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int RATE_STEP = 10,
  parameter int TRIG_LEN  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        rateSel,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              trigSel,
  input  logic              dataMsb,
  output logic [ADDR_W-1:0] memAddr,
  output logic              sampleEn,
  output logic              filterOn,
  output logic              trigOut
);

  lpagStrobe_t strb;
  logic        atTop;

  lpag_ctrl #(.RATE_STEP(RATE_STEP), .NUM_RATES(6)) uCtrl (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .atTop(atTop),
    .strb(strb), .filterOn(filterOn)
  );

  lpag_dpath #(.ADDR_W(ADDR_W), .TRIG_LEN(TRIG_LEN)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .trigSel(trigSel), .dataMsb(dataMsb), .memAddr(memAddr),
    .atTop(atTop), .trigOut(trigOut)
  );

  assign sampleEn = strb.tick;

endmodule

// File: tb/loop_playback_addr_test.sv
module loop_playback_addr_test;

  localparam int AW   = 5;
  localparam int STEP = 2;
  localparam int TLEN = 3;
  localparam int TOP  = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    rateSel = 3'd0;
  logic [AW-1:0] startAddr = '0;
  logic          trigSel = 1'b0;
  logic          dataMsb;
  logic [AW-1:0] memAddr;
  logic          sampleEn, filterOn, trigOut;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  // memory model: word MSB taken from address bit 2
  assign dataMsb = memAddr[2];

  loop_playback_addr #(.ADDR_W(AW), .RATE_STEP(STEP), .TRIG_LEN(TLEN)) uut (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .startAddr(startAddr),
    .trigSel(trigSel), .dataMsb(dataMsb), .memAddr(memAddr),
    .sampleEn(sampleEn), .filterOn(filterOn), .trigOut(trigOut)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (rate %0d start %0d tsel %0d)",
               req, act, exp, rateSel, startAddr, trigSel);
    end
  endtask

  function automatic int divOf(input int code);
    int d;
    d = 1;
    if (code >= 1 && code <= 5)
      for (int i = 0; i < code; i++) d = d * STEP;
    return d;
  endfunction

  function automatic int addrAfter(input int k, input int st);
    int len;
    len = TOP - st + 1;
    if (k == 0) return TOP;
    return st + ((k - 1) % len);
  endfunction

  task automatic runCase(input int code, input int st, input bit tsel);
    int per, len, ticks, cycles, expTrig;
    per = divOf(code);
    len = TOP - st + 1;
    @(negedge clk);
    rstN = 1'b0;
    rateSel = 3'(code);
    startAddr = AW'(st);
    trigSel = tsel;
    @(negedge clk);
    check("R1", memAddr, TOP);
    check("R1", trigOut, 0);
    check("R3", filterOn, (code != 0) ? 1 : 0);
    rstN = 1'b1;
    cycles = per * (2 * len + 6);
    for (int m = 1; m <= cycles; m++) begin
      @(posedge clk);
      @(negedge clk);
      ticks = m / per;
      check("R2", sampleEn, (((m + 1) % per) == 0) ? 1 : 0);
      if (st == TOP)
        check("R7", memAddr, TOP);
      else if (ticks >= 1 && ((ticks - 1) % len) == 0)
        check("R5", memAddr, st);
      else
        check("R4", memAddr, addrAfter(ticks, st));
      if (tsel) begin
        expTrig = (ticks == 0) ? 0 : ((addrAfter(ticks - 1, st) >> 2) & 1);
        check("R8", trigOut, expTrig);
      end else begin
        expTrig = (ticks >= 1 && ((ticks - 1) % len) < TLEN) ? 1 : 0;
        if (st == TOP) check("R7", trigOut, expTrig);
        else           check("R6", trigOut, expTrig);
      end
    end
  endtask

  initial begin
    int starts [4];
    starts = '{0, 20, TOP - 1, TOP};
    repeat (2) @(negedge clk);
    for (int code = 0; code < 8; code++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 2; t++)
          runCase(code, starts[s], t[0]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule